// File: doc/BRIEF.md
# Coherency Unit Control Register Block

This block is the register front end of a cluster coherency unit. A simple register bus reaches it with an 8-bit byte offset, separate read and write strobes, an access size given as a byte count, and 32-bit data in each direction. Inside it keeps two pieces of state: a one-bit enable for the unit and a 32-bit word that records the power state of each core. The power word can be updated one, two or four bytes at a time, starting at any of its four byte offsets.

A third register is read-only. It reports the number of cores fitted, both as a count and as a bit mask, and comes from the `NUM_CORES` parameter. Every other offset in the 256-byte window reads as zero and ignores writes. This includes the invalidate, filter-range and access-control locations, since the unit does no real snooping, filtering or access checks. Read data is registered. It appears one cycle after the read strobe and holds until the next read.

Top module: `snoop_regs`

## Requirements
- R1: After reset the enable bit and the power word are zero and `rd_data` is zero.
- R2: A write at offset 0x00 stores only bit 0 of `wr_data` as the enable bit. A read at 0x00 returns that bit in bit 0 with all other bits zero.
- R3: A read at offset 0x04 returns the configuration word `((2**NUM_CORES - 1) << 4) | (NUM_CORES - 1)`, which is 0xF3 for four cores. Writes at 0x04 change no state.
- R4: A write at offset 0x08 + k, with k from 0 to 3, replaces the power-word bits covered by the access mask shifted left by 8*k. Those bits take the masked write data shifted by the same amount. All other power-word bits keep their value.
- R5: The access mask is 0xFF when `acc_size` is 1, 0xFFFF when it is 2 and 0xFFFFFFFF when it is 4. Mask bits shifted past bit 31 are lost, so a 2-byte write at 0x0B changes only bits 31:24, taking them from `wr_data[7:0]`.
- R6: A write whose `acc_size` is any value other than 1, 2 or 4 changes neither the enable bit nor the power word, at any offset.
- R7: A read at 0x08 returns the whole power word. Reads at 0x09, 0x0A and 0x0B return the word shifted right by 8, 16 and 24 bits, with zeros filled in from the top.
- R8: Every offset other than 0x00, 0x04 and 0x08 to 0x0B reads as zero, and a write there leaves the enable bit and the power word unchanged. This covers 0x0C, 0x40, 0x44, 0x50 and 0x54.
- R9: `rd_data` takes the selected value on the clock edge that samples `rd_en` high, and holds it while `rd_en` is low.
- R10: When `rd_en` and `wr_en` are high in the same cycle, the read returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset in the register window |
| acc_size | input | 3 | Access width in bytes (1, 2 or 4 valid) |
| wr_data | input | 32 | Write data, right-aligned to the access |
| rd_data | output | 32 | Registered read data |

## Verification
The bench writes each power-word lane with each size, including the 2-byte and 4-byte writes that run off the top of the word. A design that wrapped the mask or failed to clear the lane would corrupt low bytes or keep stale bits. Writes with sizes 0, 3 and 7 aim at both live registers; a design that defaulted the mask to a full word would change state. Writes to reserved offsets are followed by reads of the real registers, and a read in the same cycle as a write to the same register is checked for pre-write data. A design with a combinational bypass or a loose offset decode would show new or aliased values there. Idle cycles with a moving address check that the read data holds and does not follow the bus.

// File: rtl/snp_pkg.sv
package snp_pkg;

    localparam int SNP_DW     = 32;
    localparam int SNP_LANES  = SNP_DW / 8;
    localparam int SNP_LANE_W = $clog2(SNP_LANES);

    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_CONFIG = 8'h04;
    localparam logic [5:0] OFS_PWR_WORD = 6'h02;   // 0x08..0x0B share addr[7:2]

    typedef enum logic [1:0] {
        ACC_BYTE,
        ACC_HALF,
        ACC_WORD,
        ACC_BAD
    } acc_kind_t;

    typedef struct packed {
        logic              enable;
        logic [SNP_DW-1:0] pwr;
        logic [SNP_DW-1:0] rdata;
    } snp_state_t;

endpackage

// File: rtl/snp_size_mask.sv
module snp_size_mask
    import snp_pkg::*;
(
    input  logic [2:0]        acc_size,
    output logic [SNP_DW-1:0] mask,
    output logic              size_ok
);

    acc_kind_t kind;

    always_comb begin
        unique case (acc_size)
            3'd1:    kind = ACC_BYTE;
            3'd2:    kind = ACC_HALF;
            3'd4:    kind = ACC_WORD;
            default: kind = ACC_BAD;
        endcase
    end

    always_comb begin
        mask    = '0;
        size_ok = 1'b1;
        unique case (kind)
            ACC_BYTE: mask = SNP_DW'(32'h0000_00FF);
            ACC_HALF: mask = SNP_DW'(32'h0000_FFFF);
            ACC_WORD: mask = '1;
            default:  size_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/snp_lane_merge.sv
module snp_lane_merge
    import snp_pkg::*;
(
    input  logic [SNP_DW-1:0]     old_word,
    input  logic [SNP_DW-1:0]     wr_data,
    input  logic [SNP_DW-1:0]     mask,
    input  logic [SNP_LANE_W-1:0] lane,
    output logic [SNP_DW-1:0]     new_word
);

    // Each destination byte looks back to the source byte (dst - lane);
    // source bytes that would land beyond the top lane are simply lost.
    for (genvar b = 0; b < SNP_LANES; b++) begin : g_lane
        localparam logic [SNP_LANE_W-1:0] DST = SNP_LANE_W'(b);

        logic [SNP_LANE_W-1:0] src;
        logic                  reach;
        logic                  take;

        always_comb begin
            src   = DST - lane;
            reach = (DST >= lane);
            take  = reach & mask[{src, 3'b000}];
            new_word[b*8 +: 8] = take ? wr_data[{src, 3'b000} +: 8]
                                      : old_word[b*8 +: 8];
        end
    end

endmodule

// File: rtl/snp_cfg_word.sv
module snp_cfg_word
    import snp_pkg::*;
#(
    parameter int NUM_CORES = 4
)(
    output logic [SNP_DW-1:0] cfg
);

    localparam int CNT_W = 4;

    logic [SNP_DW-1:0] present;

    for (genvar c = 0; c < SNP_DW; c++) begin : g_bit
        if (c >= CNT_W && c < CNT_W + NUM_CORES) begin : g_on
            assign present[c] = 1'b1;
        end else begin : g_off
            assign present[c] = 1'b0;
        end
    end

    assign cfg = present | SNP_DW'(NUM_CORES - 1);

endmodule

// File: rtl/snp_read_sel.sv
module snp_read_sel
    import snp_pkg::*;
(
    input  logic [7:0]        addr,
    input  logic              enable,
    input  logic [SNP_DW-1:0] pwr,
    input  logic [SNP_DW-1:0] cfg,
    output logic [SNP_DW-1:0] data
);

    always_comb begin
        data = '0;
        if (addr == OFS_ENABLE) begin
            data = SNP_DW'(enable);
        end else if (addr == OFS_CONFIG) begin
            data = cfg;
        end else if (addr[7:2] == OFS_PWR_WORD) begin
            data = pwr >> {addr[1:0], 3'b000};
        end
    end

endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
    import snp_pkg::*;
#(
    parameter int NUM_CORES = 4
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [2:0]  acc_size,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);

    snp_state_t cur_q;
    snp_state_t nxt_d;

    logic [SNP_DW-1:0] mask;
    logic              size_ok;
    logic [SNP_DW-1:0] merged;
    logic [SNP_DW-1:0] cfg;
    logic [SNP_DW-1:0] sel_data;

    snp_size_mask u_mask (
        .acc_size (acc_size),
        .mask     (mask),
        .size_ok  (size_ok)
    );

    snp_lane_merge u_merge (
        .old_word (cur_q.pwr),
        .wr_data  (wr_data),
        .mask     (mask),
        .lane     (addr[SNP_LANE_W-1:0]),
        .new_word (merged)
    );

    snp_cfg_word #(.NUM_CORES(NUM_CORES)) u_cfg (
        .cfg (cfg)
    );

    snp_read_sel u_rsel (
        .addr   (addr),
        .enable (cur_q.enable),
        .pwr    (cur_q.pwr),
        .cfg    (cfg),
        .data   (sel_data)
    );

    always_comb begin
        nxt_d = cur_q;
        if (rd_en) begin
            nxt_d.rdata = sel_data;
        end
        if (wr_en && size_ok) begin
            if (addr == OFS_ENABLE) begin
                nxt_d.enable = wr_data[0];
            end else if (addr[7:2] == OFS_PWR_WORD) begin
                nxt_d.pwr = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_data = cur_q.rdata;

endmodule

// File: rtl/snoop_regs_chk.sv
module snoop_regs_chk #(
    parameter int NUM_CORES = 4
)(
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  addr,
    input logic [2:0]  acc_size,
    input logic [31:0] rd_data,
    input logic        enable_q,
    input logic [31:0] pwr_q
);

    localparam logic [31:0] CFG_EXP =
        ((32'(2 ** NUM_CORES) - 32'd1) << 4) | 32'(NUM_CORES - 1);

    logic size_bad;
    logic live_ofs;
    assign size_bad = !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4);
    assign live_ofs = (addr == 8'h00) || (addr == 8'h04) || (addr[7:2] == 6'h02);

    assert_enable_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h00) |=> (rd_data[31:1] == 31'd0));

    assert_config_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h04) |=> (rd_data == CFG_EXP));

    assert_top_lane_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h0B) |=> (rd_data[31:8] == 24'd0));

    assert_bad_size_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size_bad) |=> ($stable(pwr_q) && $stable(enable_q)));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !live_ofs) |=> (rd_data == 32'd0));

    assert_reserved_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !live_ofs) |=> ($stable(pwr_q) && $stable(enable_q)));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data));

endmodule

bind snoop_regs snoop_regs_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .acc_size (acc_size),
    .rd_data  (rd_data),
    .enable_q (cur_q.enable),
    .pwr_q    (cur_q.pwr)
);

// File: tb/snoop_regs_test.sv
module snoop_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCORE      = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, wr_en;
    logic [7:0]  addr;
    logic [2:0]  acc_size;
    logic [31:0] wr_data;
    logic [31:0] rd_data;

    int tests  = 0;
    int failed = 0;

    logic        m_en;
    logic [31:0] m_pwr;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_regs #(.NUM_CORES(NCORE)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .acc_size (acc_size),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    function automatic logic [31:0] cfg_model();
        logic [31:0] v = 32'(NCORE - 1);
        for (int i = 0; i < NCORE; i++) v[4 + i] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_en};
            8'h04: return cfg_model();
            8'h08: return m_pwr;
            8'h09: return m_pwr >> 8;
            8'h0A: return m_pwr >> 16;
            8'h0B: return m_pwr >> 24;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
        logic [63:0] mk;
        int sh;
        case (s)
            3'd1: mk = 64'h0000_00FF;
            3'd2: mk = 64'h0000_FFFF;
            3'd4: mk = 64'hFFFF_FFFF;
            default: return;
        endcase
        if (a == 8'h00) begin
            m_en = d[0];
        end else if (a >= 8'h08 && a <= 8'h0B) begin
            sh = (int'(a) - 8) * 8;
            m_pwr = (m_pwr & ~32'(mk << sh)) | 32'((64'(d) & mk) << sh);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, update the model at the
    // rising edge, compare the registered read data at the next falling edge.
    task automatic step(input logic r, input logic w, input logic [7:0] a,
                        input logic [2:0] s, input logic [31:0] d, input string tag);
        rd_en = r; wr_en = w; addr = a; acc_size = s; wr_data = d;
        @(posedge clk);
        if (r) m_rd = model_read(a);
        if (w) model_write(a, s, d);
        @(negedge clk);
        check(tag, rd_data, m_rd);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d, input string tag);
        step(1'b0, 1'b1, a, s, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b1, 1'b0, a, 3'd4, 32'd0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failed++;
        $display("FAIL watchdog: rd_data=%h expected completion", rd_data);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [7:0] ofs [14] = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
                                 8'h40, 8'h44, 8'h50, 8'h54, 8'h10, 8'h7F, 8'hFF};
        logic [2:0] szs [6]  = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};

        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        addr = 8'h00; acc_size = 3'd4; wr_data = 32'd0;
        m_en = 1'b0; m_pwr = 32'd0; m_rd = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", rd_data, 32'd0);
        rd(8'h00, "R1");
        rd(8'h08, "R1");

        // R2: only bit 0 is kept
        wr(8'h00, 3'd4, 32'hFFFF_FFFE, "R2");
        rd(8'h00, "R2");
        check("R2", rd_data, 32'd0);
        wr(8'h00, 3'd1, 32'h0000_0003, "R2");
        rd(8'h00, "R2");
        check("R2", rd_data, 32'd1);

        // R3: configuration word, read-only
        rd(8'h04, "R3");
        check("R3", rd_data, 32'h0000_00F3);
        wr(8'h04, 3'd4, 32'hFFFF_FFFF, "R3");
        rd(8'h04, "R3");
        rd(8'h00, "R3");

        // R4 / R5: lane writes of each size
        wr(8'h08, 3'd4, 32'h1122_3344, "R4");
        rd(8'h08, "R4");
        check("R4", rd_data, 32'h1122_3344);
        wr(8'h09, 3'd1, 32'hFFFF_FFAB, "R4");
        rd(8'h08, "R4");
        check("R4", rd_data, 32'h1122_AB44);
        wr(8'h0A, 3'd2, 32'hAAAA_5566, "R5");
        rd(8'h08, "R5");
        check("R5", rd_data, 32'h5566_AB44);
        wr(8'h0B, 3'd2, 32'h0000_C3D4, "R5");
        rd(8'h08, "R5");
        check("R5", rd_data, 32'hD466_AB44);
        wr(8'h09, 3'd4, 32'h0102_0304, "R5");
        rd(8'h08, "R5");
        check("R5", rd_data, 32'h0203_0444);

        // R7: shifted reads
        rd(8'h09, "R7");
        check("R7", rd_data, 32'h0002_0304);
        rd(8'h0A, "R7");
        rd(8'h0B, "R7");
        check("R7", rd_data, 32'h0000_0002);

        // R6: illegal sizes leave everything alone
        wr(8'h08, 3'd0, 32'hFFFF_FFFF, "R6");
        wr(8'h08, 3'd3, 32'hFFFF_FFFF, "R6");
        wr(8'h0A, 3'd7, 32'hFFFF_FFFF, "R6");
        wr(8'h00, 3'd0, 32'h0000_0000, "R6");
        rd(8'h08, "R6");
        check("R6", rd_data, 32'h0203_0444);
        rd(8'h00, "R6");
        check("R6", rd_data, 32'd1);

        // R8: reserved offsets read zero and take no writes
        foreach (ofs[i]) begin
            if (i >= 6) begin
                wr(ofs[i], 3'd4, 32'hFFFF_FFFF, "R8");
                rd(ofs[i], "R8");
            end
        end
        rd(8'h08, "R8");
        rd(8'h00, "R8");

        // R9: data holds while idle and the address wanders
        rd(8'h04, "R9");
        step(1'b0, 1'b0, 8'h08, 3'd4, 32'd0, "R9");
        step(1'b0, 1'b0, 8'h00, 3'd4, 32'd0, "R9");
        check("R9", rd_data, 32'h0000_00F3);

        // R10: read and write together give the old contents
        step(1'b1, 1'b1, 8'h08, 3'd4, 32'hCAFE_F00D, "R10");
        check("R10", rd_data, 32'h0203_0444);
        rd(8'h08, "R10");
        check("R10", rd_data, 32'hCAFE_F00D);
        step(1'b1, 1'b1, 8'h00, 3'd4, 32'd0, "R10");
        check("R10", rd_data, 32'd1);

        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            step(1'($urandom), 1'($urandom), ofs[$urandom % 14], szs[$urandom % 6],
                 $urandom, "R9");
        end

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule